// File: doc/BRIEF.md
# Regular-Opcode Operand and Operation Decoder

This block is a purely combinational front end for an 8-bit accumulator-style processor. It takes a single opcode byte and sorts it into the columns of the regular opcode map. The high nibble gives the operation class. The low nibble gives how the primary operand is addressed. From these the block also reports the register number, the total instruction length in bytes, which status flags the operation writes, and whether the opcode is one of the logic forms whose result goes to a memory byte.

Any opcode that the regular rules do not cover is marked invalid and irregular. A separate decoder for the irregular group picks it up from that flag. When an opcode is invalid, every other field is driven to zero, so that later stages can OR the two decoders' outputs without extra muxing. Executing the operation is left to the datapath.

Top module: `regop_decoder`

## Requirements
- R1: For a valid opcode, `op_class_o` equals the high nibble. The codes 0 to 15 mean, in this order: increment, decrement, add, add with carry, OR, AND, XOR, move immediate, move to direct, subtract with borrow, move from direct, compare-and-jump-if-not-equal, exchange with accumulator, decrement-and-jump-if-nonzero, load accumulator, store accumulator.
- R2: Low nibble 8 to F gives `mode_o`=1 (register) with `reg_idx_o` = low nibble minus 8. Low nibble 6 or 7 gives `mode_o`=2 (indirect) with `reg_idx_o` = low bit (0 or 1). In every other case `reg_idx_o` is 0.
- R3: Low nibble 5 gives `mode_o`=3 (direct byte). Low nibble 4 gives `mode_o`=4 (immediate byte) for classes 2, 3, 4, 5, 6, 9 and 11. In class 11 this means the accumulator is compared with an immediate (nibble 4) or with a direct byte (nibble 5).
- R4: Low nibble 4 gives `mode_o`=5 (accumulator) for classes 0, 1 and 7.
- R5: Opcodes 0x84, 0xA4, 0xA5, 0xC4, 0xD4, 0xE4, 0xF4, 0xD6 and 0xD7 are invalid.
- R6: Opcodes with low nibble 0 to 3 are invalid, except the forms listed in R7.
- R7: 0x42, 0x52 and 0x62 are valid with `mem_dst_o`=1, `mode_o`=3 and length 2. 0x43, 0x53 and 0x63 are valid with `mem_dst_o`=1, `mode_o`=6 (direct destination with immediate source) and length 3. No other opcode sets `mem_dst_o`.
- R8: `len_o` = 1, plus 1 for mode 3 or 4, plus 2 for mode 6, plus 1 extra byte for classes 7, 8, 10 and 13. Class 11 adds 1 extra byte for low nibble 4 or 5 and 2 for low nibble 6 to F.
- R9: `flag_we_o` is 3 (all arithmetic flags) for classes 2, 3 and 9, is 1 (carry only) for class 11, and is 0 otherwise.
- R10: `irregular_o` is always the inverse of `valid_o`. An invalid opcode drives the class, mode, register, length, flag and memory-destination outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 8 | Opcode byte to decode |
| valid_o | output | 1 | Opcode belongs to the regular map |
| irregular_o | output | 1 | Opcode must be handled by the irregular decoder |
| op_class_o | output | 4 | Operation class |
| mode_o | output | 3 | Primary operand addressing mode |
| reg_idx_o | output | 3 | Register number for register or indirect mode |
| len_o | output | 2 | Instruction length in bytes |
| flag_we_o | output | 2 | Status flag write select |
| mem_dst_o | output | 1 | Result is written to a direct memory byte |

## Verification
The bench builds the block with its default 8-bit opcode width. At this width the whole input space is only 256 values, so the bench applies every opcode. Every field of each one is compared against values worked out arithmetically from the nibble rules. This covers every unused code, every repurposed combination and every length corner, not just a sample of them.

// File: rtl/regop_pkg.sv
package regop_pkg;

    localparam int MODE_W = 3;
    localparam int FW_W   = 2;

    typedef enum logic [3:0] {
        OPC_INC, OPC_DEC, OPC_ADD, OPC_ADDC, OPC_OR, OPC_AND, OPC_XOR, OPC_MOVI,
        OPC_MOVD, OPC_SUBB, OPC_MOVFD, OPC_CMPJ, OPC_XCHA, OPC_DECJ, OPC_LDA, OPC_STA
    } op_class_e;

    typedef enum logic [MODE_W-1:0] {
        MD_NONE   = 3'd0,
        MD_REG    = 3'd1,
        MD_IND    = 3'd2,
        MD_DIR    = 3'd3,
        MD_IMM    = 3'd4,
        MD_ACC    = 3'd5,
        MD_DIRIMM = 3'd6
    } mode_e;

    typedef enum logic [FW_W-1:0] {
        FW_NONE  = 2'd0,
        FW_CARRY = 2'd1,
        FW_ALL   = 2'd3
    } flagw_e;

    typedef struct packed {
        logic       valid;
        logic       mem_dst;
        logic [3:0] cls;
        mode_e      mode;
        logic [2:0] ridx;
        logic [1:0] len;
        flagw_e     fw;
    } dec_t;

endpackage

// File: rtl/regop_mode.sv
module regop_mode #(
    parameter int NIB_W  = 4,
    parameter int RIDX_W = NIB_W - 1
) (
    input  logic [NIB_W-1:0]  hi_i,
    input  logic [NIB_W-1:0]  lo_i,
    output regop_pkg::mode_e  mode_o,
    output logic [RIDX_W-1:0] ridx_o
);
    import regop_pkg::*;

    logic acc_col;

    // Column 4 names the accumulator for the destination-only classes
    // and for the class that already carries its own immediate.
    assign acc_col = (hi_i == NIB_W'(0)) || (hi_i == NIB_W'(1)) || (hi_i == NIB_W'(7));

    always_comb begin
        mode_o = MD_NONE;
        ridx_o = '0;
        if (lo_i[NIB_W-1]) begin
            mode_o = MD_REG;
            ridx_o = lo_i[RIDX_W-1:0];
        end else begin
            case (lo_i[NIB_W-2:0])
                3'd6, 3'd7: begin
                    mode_o = MD_IND;
                    ridx_o = RIDX_W'(lo_i[0]);
                end
                3'd5:    mode_o = MD_DIR;
                3'd4:    mode_o = acc_col ? MD_ACC : MD_IMM;
                3'd3:    mode_o = MD_DIRIMM;
                3'd2:    mode_o = MD_DIR;
                default: mode_o = MD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/regop_legal.sv
module regop_legal #(
    parameter int OPC_W = 8,
    parameter int NIB_W = OPC_W / 2
) (
    input  logic [OPC_W-1:0] opcode_i,
    output logic             valid_o,
    output logic             mem_dst_o
);
    logic [NIB_W-1:0] hi;
    logic [NIB_W-1:0] lo;
    logic             logic_cls;
    logic             low_grp;
    logic             unused;

    assign hi        = opcode_i[OPC_W-1:NIB_W];
    assign lo        = opcode_i[NIB_W-1:0];
    assign logic_cls = (hi >= NIB_W'(4)) && (hi <= NIB_W'(6));
    assign low_grp   = lo < NIB_W'(4);
    assign mem_dst_o = logic_cls && ((lo == NIB_W'(2)) || (lo == NIB_W'(3)));

    always_comb begin
        case (opcode_i)
            OPC_W'('h84), OPC_W'('hA4), OPC_W'('hA5), OPC_W'('hC4),
            OPC_W'('hD4), OPC_W'('hE4), OPC_W'('hF4),
            OPC_W'('hD6), OPC_W'('hD7): unused = 1'b1;
            default:                    unused = 1'b0;
        endcase
    end

    assign valid_o = (!low_grp || mem_dst_o) && !unused;

endmodule

// File: rtl/regop_size.sv
module regop_size #(
    parameter int NIB_W = 4,
    parameter int LEN_W = 2
) (
    input  logic [NIB_W-1:0]  hi_i,
    input  logic [NIB_W-1:0]  lo_i,
    input  regop_pkg::mode_e  mode_i,
    output logic [LEN_W-1:0]  len_o,
    output regop_pkg::flagw_e fw_o
);
    import regop_pkg::*;

    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] opnd_bytes;
    logic [SUM_W-1:0] extra_bytes;
    logic [SUM_W-1:0] total;

    always_comb begin
        case (mode_i)
            MD_DIR, MD_IMM: opnd_bytes = SUM_W'(1);
            MD_DIRIMM:      opnd_bytes = SUM_W'(2);
            default:        opnd_bytes = '0;
        endcase
    end

    always_comb begin
        case (hi_i)
            NIB_W'(7), NIB_W'(8), NIB_W'(10), NIB_W'(13): extra_bytes = SUM_W'(1);
            NIB_W'(11): extra_bytes = (lo_i >= NIB_W'(6)) ? SUM_W'(2) : SUM_W'(1);
            default:    extra_bytes = '0;
        endcase
    end

    assign total = SUM_W'(1) + opnd_bytes + extra_bytes;
    assign len_o = total[LEN_W-1:0];

    always_comb begin
        case (hi_i)
            NIB_W'(2), NIB_W'(3), NIB_W'(9): fw_o = FW_ALL;
            NIB_W'(11):                      fw_o = FW_CARRY;
            default:                         fw_o = FW_NONE;
        endcase
    end

endmodule

// File: rtl/regop_decoder.sv
module regop_decoder #(
    parameter int OPC_W = 8
) (
    input  logic [OPC_W-1:0]             opcode_i,
    output logic                         valid_o,
    output logic                         irregular_o,
    output logic [OPC_W/2-1:0]           op_class_o,
    output logic [regop_pkg::MODE_W-1:0] mode_o,
    output logic [OPC_W/2-2:0]           reg_idx_o,
    output logic [1:0]                   len_o,
    output logic [regop_pkg::FW_W-1:0]   flag_we_o,
    output logic                         mem_dst_o
);
    import regop_pkg::*;

    localparam int NIB_W  = OPC_W / 2;
    localparam int RIDX_W = NIB_W - 1;

    logic [NIB_W-1:0]  hi;
    logic [NIB_W-1:0]  lo;
    mode_e             mode_w;
    logic [RIDX_W-1:0] ridx_w;
    logic              legal_w;
    logic              memdst_w;
    logic [1:0]        len_w;
    flagw_e            fw_w;
    dec_t              dec_d;

    assign hi = opcode_i[OPC_W-1:NIB_W];
    assign lo = opcode_i[NIB_W-1:0];

    regop_mode #(.NIB_W(NIB_W), .RIDX_W(RIDX_W)) u_mode (
        .hi_i   (hi),
        .lo_i   (lo),
        .mode_o (mode_w),
        .ridx_o (ridx_w)
    );

    regop_legal #(.OPC_W(OPC_W), .NIB_W(NIB_W)) u_legal (
        .opcode_i  (opcode_i),
        .valid_o   (legal_w),
        .mem_dst_o (memdst_w)
    );

    regop_size #(.NIB_W(NIB_W), .LEN_W(2)) u_size (
        .hi_i   (hi),
        .lo_i   (lo),
        .mode_i (mode_w),
        .len_o  (len_w),
        .fw_o   (fw_w)
    );

    // Invalid opcodes leave every field at zero so the two decoders can be merged by OR.
    always_comb begin
        dec_d = '0;
        if (legal_w) begin
            dec_d.valid   = 1'b1;
            dec_d.mem_dst = memdst_w;
            dec_d.cls     = 4'(hi);
            dec_d.mode    = mode_w;
            dec_d.ridx    = 3'(ridx_w);
            dec_d.len     = len_w;
            dec_d.fw      = fw_w;
        end
    end

    assign valid_o     = dec_d.valid;
    assign irregular_o = !dec_d.valid;
    assign op_class_o  = NIB_W'(dec_d.cls);
    assign mode_o      = dec_d.mode;
    assign reg_idx_o   = RIDX_W'(dec_d.ridx);
    assign len_o       = dec_d.len;
    assign flag_we_o   = dec_d.fw;
    assign mem_dst_o   = dec_d.mem_dst;

endmodule

// File: rtl/regop_decoder_chk.sv
module regop_decoder_chk (
    input logic [7:0] opcode_i,
    input logic       valid_o,
    input logic       irregular_o,
    input logic [3:0] op_class_o,
    input logic [2:0] mode_o,
    input logic [2:0] reg_idx_o,
    input logic [1:0] len_o,
    input logic [1:0] flag_we_o,
    input logic       mem_dst_o
);
    logic [3:0] lo;
    assign lo = opcode_i[3:0];

    always_comb begin
        a_r10_valid_irregular: assert (valid_o != irregular_o);
        if (!valid_o) begin
            a_r10_invalid_zero: assert (len_o == 2'd0 && mode_o == 3'd0 && flag_we_o == 2'd0
                                        && op_class_o == 4'd0 && !mem_dst_o);
        end else begin
            a_r8_len_range: assert (len_o != 2'd0);
        end
        if (opcode_i == 8'hA5 || opcode_i == 8'hD6 || opcode_i == 8'hD7 || opcode_i == 8'h84) begin
            a_r5_unused: assert (!valid_o);
        end
        if (lo < 4'd4 && !mem_dst_o) begin
            a_r6_low_group: assert (!valid_o);
        end
        if (mem_dst_o) begin
            a_r7_memdst_form: assert (valid_o && (lo == 4'd2 || lo == 4'd3));
        end
        if (flag_we_o == 2'd3) begin
            a_r9_all_flags: assert (op_class_o == 4'd2 || op_class_o == 4'd3 || op_class_o == 4'd9);
        end
        if (flag_we_o == 2'd1) begin
            a_r9_carry_only: assert (op_class_o == 4'd11);
        end
        if (mode_o == 3'd1) begin
            a_r2_reg_index: assert (lo[3] && reg_idx_o == lo[2:0]);
        end
    end

endmodule

bind regop_decoder regop_decoder_chk u_chk (
    .opcode_i    (opcode_i),
    .valid_o     (valid_o),
    .irregular_o (irregular_o),
    .op_class_o  (op_class_o),
    .mode_o      (mode_o),
    .reg_idx_o   (reg_idx_o),
    .len_o       (len_o),
    .flag_we_o   (flag_we_o),
    .mem_dst_o   (mem_dst_o)
);

// File: tb/tb_regop_decoder.sv
`timescale 1ns/1ps
module tb_regop_decoder;

    logic       clk = 1'b0;
    logic [7:0] opcode_i = 8'h00;
    logic       valid_o, irregular_o, mem_dst_o;
    logic [3:0] op_class_o;
    logic [2:0] mode_o, reg_idx_o;
    logic [1:0] len_o, flag_we_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    regop_decoder dut (
        .opcode_i    (opcode_i),
        .valid_o     (valid_o),
        .irregular_o (irregular_o),
        .op_class_o  (op_class_o),
        .mode_o      (mode_o),
        .reg_idx_o   (reg_idx_o),
        .len_o       (len_o),
        .flag_we_o   (flag_we_o),
        .mem_dst_o   (mem_dst_o)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s op=%02h actual=%0d expected=%0d", req, what, opcode_i, got, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int op = 0; op < 256; op++) begin
            int hi, lo, e_mode, e_reg, e_len, e_fw, e_cls;
            bit unused, low, md, ok;
            string mtag;
            @(posedge clk);
            opcode_i = 8'(op);
            hi = op / 16;
            lo = op % 16;
            unused = (op == 'h84) || (op == 'hA4) || (op == 'hA5) || (op == 'hC4) ||
                     (op == 'hD4) || (op == 'hE4) || (op == 'hF4) || (op == 'hD6) || (op == 'hD7);
            low = lo < 4;
            md  = (hi >= 4 && hi <= 6) && (lo == 2 || lo == 3);
            ok  = !unused && (!low || md);
            e_cls = 0; e_mode = 0; e_reg = 0; e_len = 0; e_fw = 0;
            if (ok) begin
                e_cls = hi;
                if (lo >= 8)                                e_mode = 1;
                else if (lo >= 6)                           e_mode = 2;
                else if (lo == 5 || lo == 2)                e_mode = 3;
                else if (lo == 4)                           e_mode = (hi <= 1 || hi == 7) ? 5 : 4;
                else                                        e_mode = 6;
                e_reg = (lo >= 8) ? lo - 8 : ((lo >= 6) ? lo - 6 : 0);
                e_len = 1 + ((e_mode == 3 || e_mode == 4) ? 1 : 0) + ((e_mode == 6) ? 2 : 0);
                if (hi == 7 || hi == 8 || hi == 10 || hi == 13) e_len += 1;
                if (hi == 11) e_len += (lo >= 6) ? 2 : 1;
                e_fw = (hi == 2 || hi == 3 || hi == 9) ? 3 : ((hi == 11) ? 1 : 0);
            end
            if (!ok)                                      mtag = unused ? "R5" : "R6";
            else if (md)                                  mtag = "R7";
            else if (lo >= 6)                             mtag = "R2";
            else if (lo == 4 && (hi <= 1 || hi == 7))     mtag = "R4";
            else                                          mtag = "R3";
            @(negedge clk);
            check(unused ? "R5" : "R6", "valid", int'(valid_o), int'(ok));
            check("R10", "irregular", int'(irregular_o), int'(!ok));
            check("R1", "class", int'(op_class_o), e_cls);
            check(mtag, "mode", int'(mode_o), e_mode);
            check("R2", "reg_idx", int'(reg_idx_o), e_reg);
            check("R8", "length", int'(len_o), e_len);
            check("R9", "flag_we", int'(flag_we_o), e_fw);
            check("R7", "mem_dst", int'(mem_dst_o), int'(ok && md));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule